// File: doc/BRIEF.md
# Timestamp Width Extension Unit

This unit turns a narrow, free-running nanosecond count of `NBIT` bits into a full `OUT_W`-bit time value. It keeps an epoch counter, `EPOCH_W` bits wide, that counts wraps of the narrow count. It also keeps the two most significant bits of the last sample it accepted. Requesters such as clock reads, receive captures and transmit captures are arbitrated upstream onto one sample port. Their samples may therefore reach the unit out of time order.

The stored two-bit region splits the wrap period into quarters. A move of the top bit from one to zero marks a wrap, and the epoch advances by one. A sample in the top quarter that arrives while the stored region is the bottom quarter was latched before the wrap already recorded. Such a sample is given the previous epoch and leaves the state alone.

A full-width time may be loaded to reseed the epoch and the region. This unit is correct only while samples arrive more than four times per wrap period. A built-in timer therefore raises a request for a self-sample when `SELF_PERIOD` cycles pass without an accepted sample.

Top module: `tstamp_extend`

## Requirements
- R1: The result is the epoch in use placed directly above the `NBIT`-bit sample, truncated or zero-extended to `OUT_W` bits. The region of a sample is its bits `[NBIT-1:NBIT-2]`.
- R2: A sample whose region is 11b is stale when the stored region is 00b. A stale sample yields epoch minus one and raises `res_stale_o`. It changes neither the epoch nor the stored region.
- R3: A non-stale sample that has bit 1 of its region clear, while the stored region has bit 1 set, increments the epoch modulo 2^EPOCH_W. The increment happens before the result is formed.
- R4: A non-stale sample stores its region as the new stored region.
- R5: When a stale sample meets an epoch of zero, the epoch used is all ones.
- R6: An accepted load sets the epoch to the loaded time shifted right by `NBIT`, truncated to `EPOCH_W` bits. It sets the stored region to bits `[NBIT-1:NBIT-2]` of the loaded time.
- R7: A load is always accepted (`ld_ready_o` is 1). While `ld_valid_i` is high, `smp_ready_o` is low and a presented sample is not consumed.
- R8: Each accepted sample produces exactly one `res_valid_o` pulse on the cycle after the handshake. No result appears without an accepted sample.
- R9: `self_req_o` rises once `SELF_PERIOD` consecutive cycles pass with no accepted sample. It stays high until a sample is accepted, and falls on the next cycle.
- R10: A synchronous active-high reset clears the epoch, the stored region, the self-sample timer and `res_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample offered |
| smp_ready_o | output | 1 | Sample can be taken this cycle |
| smp_data_i | input | NBIT | Narrow nanosecond sample |
| ld_valid_i | input | 1 | Load of a full time offered |
| ld_ready_o | output | 1 | Load can be taken (always 1) |
| ld_time_i | input | OUT_W | Full time to load |
| res_valid_o | output | 1 | Extended result valid (one cycle) |
| res_time_o | output | OUT_W | Extended time |
| res_stale_o | output | 1 | Result was given the previous epoch |
| self_req_o | output | 1 | Request for a self-sample |

## Verification
Directed sequences walk the stored region through each quarter to separate three behaviours: a true wrap from region 10b or 11b into 00b, a stale top-quarter sample after a wrap, and a plain in-quarter advance. Repeated stale samples show that the state is held, because a later 00b sample keeps the current epoch. Loads placed at epoch zero and at all ones expose the wrap of the decrement and of the increment. A load that coincides with a sample separates load priority from sample loss. Random runs mix forward walks, with jitter that sometimes backs across a wrap, with arbitrary values, so that every region pair is met against an independent bench model.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
   // Quarter of the narrow wrap period, taken from the two top sample bits
   typedef enum logic [1:0] {
      REG_Q0 = 2'b00,
      REG_Q1 = 2'b01,
      REG_Q2 = 2'b10,
      REG_Q3 = 2'b11
   } region_t;
endpackage

// File: rtl/tsx_epoch_track.sv
module tsx_epoch_track
   import tsx_pkg::*;
#(
   parameter int NBIT    = 40,
   parameter int EPOCH_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               smp_acc_i,
   input  logic [NBIT-1:0]    smp_data_i,
   input  logic               ld_acc_i,
   input  logic [EPOCH_W-1:0] ld_epoch_i,
   input  region_t            ld_region_i,
   output logic [EPOCH_W-1:0] epoch_q,
   output region_t            last_q,
   output logic [EPOCH_W-1:0] epoch_use_o,
   output logic               stale_o
);
   region_t cur_region;
   logic    crossed;

   always_comb begin
      cur_region  = region_t'(smp_data_i[NBIT-1 -: 2]);
      stale_o     = (cur_region == REG_Q3) && (last_q == REG_Q0);
      crossed     = last_q[1] & ~cur_region[1];
      if (stale_o)
         epoch_use_o = epoch_q - 1'b1;
      else if (crossed)
         epoch_use_o = epoch_q + 1'b1;
      else
         epoch_use_o = epoch_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         epoch_q <= '0;
         last_q  <= REG_Q0;
      end else if (ld_acc_i) begin
         epoch_q <= ld_epoch_i;
         last_q  <= ld_region_i;
      end else if (smp_acc_i && !stale_o) begin
         epoch_q <= epoch_use_o;
         last_q  <= cur_region;
      end
   end
endmodule

// File: rtl/tsx_compose.sv
module tsx_compose #(
   parameter int NBIT    = 40,
   parameter int EPOCH_W = 32,
   parameter int OUT_W   = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               acc_i,
   input  logic [NBIT-1:0]    data_i,
   input  logic [EPOCH_W-1:0] epoch_i,
   input  logic               stale_i,
   output logic               valid_o,
   output logic [OUT_W-1:0]   time_o,
   output logic               stale_o
);
   localparam int CAT_W = EPOCH_W + NBIT;

   logic [CAT_W-1:0] cat;
   logic [OUT_W-1:0] wide;

   assign cat = {epoch_i, data_i};

   generate
      if (CAT_W >= OUT_W) begin : g_trunc
         assign wide = cat[OUT_W-1:0];
      end else begin : g_pad
         assign wide = {{(OUT_W-CAT_W){1'b0}}, cat};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         time_o  <= '0;
         stale_o <= 1'b0;
      end else begin
         valid_o <= acc_i;
         if (acc_i) begin
            time_o  <= wide;
            stale_o <= stale_i;
         end
      end
   end
endmodule

// File: rtl/tsx_self_timer.sv
module tsx_self_timer #(
   parameter int SELF_PERIOD = 1024
) (
   input  logic clk,
   input  logic rst,
   input  logic hit_i,
   output logic req_o
);
   generate
      if (SELF_PERIOD == 0) begin : g_off
         assign req_o = 1'b0;
      end else begin : g_on
         localparam int CNT_W = $clog2(SELF_PERIOD + 1);
         localparam logic [CNT_W-1:0] LIM = CNT_W'(SELF_PERIOD);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst || hit_i)
               cnt <= '0;
            else if (cnt != LIM)
               cnt <= cnt + 1'b1;
         end
         assign req_o = (cnt == LIM);
      end
   endgenerate
endmodule

// File: rtl/tstamp_extend.sv
module tstamp_extend
   import tsx_pkg::*;
#(
   parameter int NBIT        = 40,
   parameter int EPOCH_W     = 32,
   parameter int OUT_W       = 64,
   parameter int SELF_PERIOD = 1024
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_valid_i,
   output logic             smp_ready_o,
   input  logic [NBIT-1:0]  smp_data_i,
   input  logic             ld_valid_i,
   output logic             ld_ready_o,
   input  logic [OUT_W-1:0] ld_time_i,
   output logic             res_valid_o,
   output logic [OUT_W-1:0] res_time_o,
   output logic             res_stale_o,
   output logic             self_req_o
);
   generate
      if (NBIT < 3) begin : g_chk_nbit
         $error("tstamp_extend: NBIT must be at least 3");
      end
      if (NBIT >= OUT_W) begin : g_chk_out
         $error("tstamp_extend: NBIT must be below OUT_W");
      end
      if (EPOCH_W < 1) begin : g_chk_ep
         $error("tstamp_extend: EPOCH_W must be positive");
      end
      if (SELF_PERIOD < 0) begin : g_chk_per
         $error("tstamp_extend: SELF_PERIOD must not be negative");
      end
   endgenerate

   logic               smp_acc;
   logic [EPOCH_W-1:0] ld_epoch;
   region_t            ld_region;
   logic [EPOCH_W-1:0] epoch_q;
   region_t            last_q;
   logic [EPOCH_W-1:0] epoch_use;
   logic               stale;

   assign ld_ready_o  = 1'b1;
   assign smp_ready_o = ~ld_valid_i;
   assign smp_acc     = smp_valid_i & smp_ready_o;
   assign ld_epoch    = EPOCH_W'(ld_time_i >> NBIT);
   assign ld_region   = region_t'(ld_time_i[NBIT-1 -: 2]);

   tsx_epoch_track #(.NBIT(NBIT), .EPOCH_W(EPOCH_W)) u_trk (
      .clk         (clk),
      .rst         (rst),
      .smp_acc_i   (smp_acc),
      .smp_data_i  (smp_data_i),
      .ld_acc_i    (ld_valid_i),
      .ld_epoch_i  (ld_epoch),
      .ld_region_i (ld_region),
      .epoch_q     (epoch_q),
      .last_q      (last_q),
      .epoch_use_o (epoch_use),
      .stale_o     (stale)
   );

   tsx_compose #(.NBIT(NBIT), .EPOCH_W(EPOCH_W), .OUT_W(OUT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .acc_i   (smp_acc),
      .data_i  (smp_data_i),
      .epoch_i (epoch_use),
      .stale_i (stale),
      .valid_o (res_valid_o),
      .time_o  (res_time_o),
      .stale_o (res_stale_o)
   );

   tsx_self_timer #(.SELF_PERIOD(SELF_PERIOD)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .hit_i (smp_acc),
      .req_o (self_req_o)
   );
endmodule

// File: rtl/tsx_checker.sv
module tsx_checker #(
   parameter int NBIT        = 40,
   parameter int EPOCH_W     = 32,
   parameter int OUT_W       = 64,
   parameter int SELF_PERIOD = 1024
) (
   input logic               clk,
   input logic               rst,
   input logic               smp_valid_i,
   input logic               smp_ready_o,
   input logic [NBIT-1:0]    smp_data_i,
   input logic               ld_valid_i,
   input logic [OUT_W-1:0]   ld_time_i,
   input logic               res_valid_o,
   input logic               self_req_o,
   input logic [EPOCH_W-1:0] epoch_q,
   input logic [1:0]         last_q
);
   logic acc;
   assign acc = smp_valid_i & smp_ready_o;

   assert_load_priority_R7: assert property (@(posedge clk) disable iff (rst)
      ld_valid_i |-> !smp_ready_o);

   assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
      acc |=> res_valid_o);

   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
      !acc |=> !res_valid_o);

   assert_stale_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (acc && smp_data_i[NBIT-1 -: 2] == 2'b11 && last_q == 2'b00)
      |=> ($stable(epoch_q) && $stable(last_q)));

   assert_wrap_inc_R3: assert property (@(posedge clk) disable iff (rst)
      (acc && last_q[1] && !smp_data_i[NBIT-1])
      |=> (epoch_q == $past(epoch_q) + 1'b1));

   assert_region_store_R4: assert property (@(posedge clk) disable iff (rst)
      (acc && !(smp_data_i[NBIT-1 -: 2] == 2'b11 && last_q == 2'b00))
      |=> (last_q == $past(smp_data_i[NBIT-1 -: 2])));

   assert_load_R6: assert property (@(posedge clk) disable iff (rst)
      ld_valid_i |=> (epoch_q == $past(EPOCH_W'(ld_time_i >> NBIT))
                      && last_q == $past(ld_time_i[NBIT-1 -: 2])));

   assert_selfreq_clear_R9: assert property (@(posedge clk) disable iff (rst)
      acc |=> !self_req_o);

   assert_reset_R10: assert property (@(posedge clk)
      rst |=> (epoch_q == '0 && last_q == 2'b00 && !res_valid_o && !self_req_o));
endmodule

bind tstamp_extend tsx_checker #(
   .NBIT(NBIT), .EPOCH_W(EPOCH_W), .OUT_W(OUT_W), .SELF_PERIOD(SELF_PERIOD)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .smp_valid_i (smp_valid_i),
   .smp_ready_o (smp_ready_o),
   .smp_data_i  (smp_data_i),
   .ld_valid_i  (ld_valid_i),
   .ld_time_i   (ld_time_i),
   .res_valid_o (res_valid_o),
   .self_req_o  (self_req_o),
   .epoch_q     (epoch_q),
   .last_q      (last_q)
);

// File: tb/tb_tstamp_extend.sv
`timescale 1ns/1ps
module tb_tstamp_extend;
   localparam int NBIT    = 16;
   localparam int EPOCH_W = 32;
   localparam int OUT_W   = 64;
   localparam int PER     = 40;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             smp_valid = 1'b0;
   logic             smp_ready;
   logic [NBIT-1:0]  smp_data = '0;
   logic             ld_valid = 1'b0;
   logic             ld_ready;
   logic [OUT_W-1:0] ld_time = '0;
   logic             res_valid;
   logic [OUT_W-1:0] res_time;
   logic             res_stale;
   logic             self_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [EPOCH_W-1:0] m_ep;
   logic [1:0]         m_last;

   always #2.5 clk = ~clk;

   tstamp_extend #(.NBIT(NBIT), .EPOCH_W(EPOCH_W), .OUT_W(OUT_W),
                   .SELF_PERIOD(PER)) dut (
      .clk(clk), .rst(rst),
      .smp_valid_i(smp_valid), .smp_ready_o(smp_ready), .smp_data_i(smp_data),
      .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_time_i(ld_time),
      .res_valid_o(res_valid), .res_time_o(res_time), .res_stale_o(res_stale),
      .self_req_o(self_req));

   function automatic logic [OUT_W-1:0] compose(logic [EPOCH_W-1:0] ep,
                                                logic [NBIT-1:0] d);
      return (OUT_W'(ep) << NBIT) | OUT_W'(d);
   endfunction

   task automatic chk(bit ok, string req, logic [OUT_W-1:0] act,
                      logic [OUT_W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Model step for one accepted sample; returns expected time and stale flag
   task automatic model(logic [NBIT-1:0] d, output logic [OUT_W-1:0] t,
                        output bit st);
      logic [1:0] cur = d[NBIT-1 -: 2];
      st = (cur == 2'b11) && (m_last == 2'b00);
      if (st) begin
         t = compose(m_ep - 1'b1, d);
      end else begin
         if (m_last[1] && !cur[1]) m_ep = m_ep + 1'b1;
         m_last = cur;
         t = compose(m_ep, d);
      end
   endtask

   task automatic do_sample(logic [NBIT-1:0] d, string req);
      logic [OUT_W-1:0] et;
      bit es;
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = d;
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      model(d, et, es);
      chk(res_valid && res_time == et, req, res_time, et);
      chk(res_stale == es, {req, " stale flag"}, OUT_W'(res_stale), OUT_W'(es));
   endtask

   task automatic do_load(logic [OUT_W-1:0] t);
      @(negedge clk);
      ld_valid = 1'b1;
      ld_time  = t;
      @(posedge clk);
      #1;
      ld_valid = 1'b0;
      m_ep   = EPOCH_W'(t >> NBIT);
      m_last = t[NBIT-1 -: 2];
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [OUT_W-1:0] et;
      bit es;
      logic [NBIT-1:0] walk;
      void'($urandom(32'd20240611));
      m_ep = '0;
      m_last = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R10: reset state
      chk(!res_valid && !self_req, "R10 reset outputs",
          {62'd0, res_valid, self_req}, '0);
      chk(ld_ready == 1'b1, "R7 load ready", OUT_W'(ld_ready), 64'd1);
      // R9: self request after PER idle cycles
      repeat (PER - 1) @(posedge clk);
      #1;
      chk(!self_req, "R9 self request early", OUT_W'(self_req), 64'd0);
      @(posedge clk);
      #1;
      chk(self_req, "R9 self request raised", OUT_W'(self_req), 64'd1);
      repeat (5) @(posedge clk);
      #1;
      chk(self_req, "R9 self request held", OUT_W'(self_req), 64'd1);

      // R5/R2: right after reset, epoch 0 and region 00; top-quarter sample is stale
      do_sample(16'hF123, "R5 stale at epoch zero");
      chk(!self_req, "R9 self request cleared", OUT_W'(self_req), 64'd0);
      do_sample(16'hE000, "R2 stale again, state held");
      do_sample(16'h0100, "R2 region zero keeps epoch");
      // R4/R1: plain walk through quarters
      do_sample(16'h4000, "R4 region 01");
      do_sample(16'h9000, "R1 region 10");
      do_sample(16'hC000, "R1 region 11");
      // R3: wrap from 11 into 00
      do_sample(16'h0010, "R3 wrap increments");
      do_sample(16'hFFF0, "R2 stale after wrap");
      do_sample(16'h2000, "R2 epoch unchanged by stale");
      // R3 wrap from 10 into 01
      do_sample(16'hA000, "R4 region 10");
      do_sample(16'h5000, "R3 wrap from 10 into 01");

      // R6: load then check via samples
      do_load({16'h0, 32'h1234_5678, 16'h8000});
      do_sample(16'h0001, "R6 load epoch and region, then wrap");
      // R3: epoch wraps modulo 2^32
      do_load({16'h0, 32'hFFFF_FFFF, 16'hC000});
      do_sample(16'h0002, "R3 epoch wraps to zero");
      // R6 load region 00 then stale
      do_load({16'h0, 32'h0000_0100, 16'h0000});
      do_sample(16'hF000, "R6 loaded region gives stale");

      // R7: load and sample in the same cycle
      @(negedge clk);
      ld_valid  = 1'b1;
      ld_time   = {16'h0, 32'h0000_0042, 16'h9000};
      smp_valid = 1'b1;
      smp_data  = 16'h1000;
      #1;
      chk(!smp_ready, "R7 ready low during load", OUT_W'(smp_ready), 64'd0);
      @(posedge clk);
      #1;
      ld_valid = 1'b0;
      m_ep   = 32'h0000_0042;
      m_last = 2'b10;
      chk(!res_valid, "R7 sample not consumed with load", OUT_W'(res_valid), 64'd0);
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      model(16'h1000, et, es);
      chk(res_valid && res_time == et, "R7 sample taken after load", res_time, et);
      @(posedge clk);
      #1;
      chk(!res_valid, "R8 single result pulse", OUT_W'(res_valid), 64'd0);

      // Random: forward walk with backward jitter, mixed with arbitrary values
      walk = '0;
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom % 8);
         if (r == 0) begin
            do_sample(NBIT'($urandom), "R1 random value");
         end else if (r == 1) begin
            do_sample(walk - NBIT'($urandom % 16'h0800), "R2 random jitter");
         end else begin
            walk = walk + NBIT'($urandom % 16'h3000);
            do_sample(walk, "R3 random walk");
         end
         if (i % 97 == 0) do_load(OUT_W'({$urandom, $urandom}));
      end

      // R10: reset mid-run clears state
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_ep = '0;
      m_last = 2'b00;
      chk(!res_valid && !self_req, "R10 reset mid-run",
          {62'd0, res_valid, self_req}, '0);
      do_sample(16'h8000, "R10 epoch cleared by reset");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule